// File: doc/BRIEF.md
# Timer Output Pin Event Driver

This block sits beside a free-running timer counter and turns the counter's overflow and match events into a level on the timer's output pin. Each qualifying event can do one of two things. It can invert the pin, which builds a square or PWM-style waveform out of successive events. Or it can produce a one-cycle pulse that leaves the idle level and then returns to it. A two-bit trigger mode selects which events qualify.

When the counter is stopped, or no trigger mode is selected, the pin rests at a programmable park level. When the pin direction is set to input, the driver freezes its output register so that the captured state survives until the pin is turned back to output. Inputs are sampled on the rising clock edge, and the pin register takes its new value on that same edge.

The control is a four-state machine:
- **ST_PARK**: parked. The pin follows the park level.
- **ST_TOGGLE**: toggle run. Qualifying events invert the pin.
- **ST_IDLE**: pulse idle. The pin sits at the park level.
- **ST_PULSE**: pulse active. The pin sits at the inverse of the park level.

The transitions are:
- **to_park**: the counter is stopped or no trigger mode is active.
- **to_toggle**: running with toggle selected.
- **to_pulse**: running in pulse mode with a qualifying event.
- **to_idle**: running in pulse mode without a qualifying event.
- **hold**: the pin is an input, so both the state and the pin stay as they are.

Top module: `tmr_pin_driver`

## Requirements
- R1: While reset is asserted, and after it is released with the pin as an input, the pin output is at the reset level parameter (default 0).
- R2: Trigger mode encoding:
  - 2'b00 selects no events. The pin parks.
  - 2'b01 selects overflow only.
  - 2'b10 selects overflow or match.
  - 2'b11 behaves like 2'b00.
- R3: With the toggle select at 1, the counter running and the pin an output, each cycle with a qualifying event inverts the pin on that clock edge. A cycle without a qualifying event leaves the pin unchanged.
- R4: With the toggle select at 0, the counter running and the pin an output:
  - A qualifying event drives the pin to the inverse of the park level on that edge.
  - A cycle without a qualifying event drives the pin to the park level.
  - An isolated event therefore gives a one-cycle pulse.
- R5: With the pin an output, a stopped counter (run at 0) or an inactive trigger mode drives the pin to the park level on the next edge.
- R6: With the direction at 0 (input), the pin output and the state hold regardless of events, run, mode or park level.
- R7: In mode 2'b10 with toggle selected, an overflow and a match in the same cycle invert the pin exactly once.
- R8: In mode 2'b01, a match without an overflow does not change the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt | input | 1 | Counter overflow event, one cycle |
| mat_evt | input | 1 | Counter compare match event, one cycle |
| run | input | 1 | Counter running |
| trig_mode | input | 2 | Trigger mode (see R2) |
| toggle_sel | input | 1 | 1 = toggle on event, 0 = pulse on event |
| park_lvl | input | 1 | Level used when parked and as the pulse idle level |
| dir_out | input | 1 | 1 = pin is an output, 0 = input |
| pin_out | output | 1 | Pin level |

## Verification
Overflow and match are the two events that can arrive in the same cycle. The bench raises both on one cycle in the overflow-or-match mode, twice in a row under toggle and once under pulse. A correct pin inverts once per such cycle, so two consecutive coincident cycles must leave the pin back at its level from before them. A double inversion would leave the pin unchanged after the first cycle, and the scoreboard sees that directly. Single-event cycles on either side confirm that each event on its own still qualifies.

// File: rtl/tmr_pin_pkg.sv
package tmr_pin_pkg;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_OVF  = 2'b01,
        TRIG_BOTH = 2'b10,
        TRIG_RSVD = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_PARK   = 2'b00,
        ST_TOGGLE = 2'b01,
        ST_IDLE   = 2'b10,
        ST_PULSE  = 2'b11
    } pin_state_e;

endpackage

// File: rtl/tmr_pin_qual.sv
module tmr_pin_qual
    import tmr_pin_pkg::*;
(
    input  logic       ovf_evt,
    input  logic       mat_evt,
    input  logic [1:0] trig_mode,
    output logic       trig_active,
    output logic       fire
);

    trig_mode_e mode;
    assign mode = trig_mode_e'(trig_mode);

    always_comb begin
        trig_active = 1'b0;
        fire        = 1'b0;
        unique case (mode)
            TRIG_OVF: begin
                trig_active = 1'b1;
                fire        = ovf_evt;
            end
            TRIG_BOTH: begin
                trig_active = 1'b1;
                fire        = ovf_evt | mat_evt;   // coincidence yields one event
            end
            TRIG_NONE, TRIG_RSVD: begin
                trig_active = 1'b0;
                fire        = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tmr_pin_fsm.sv
module tmr_pin_fsm
    import tmr_pin_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_out,
    input  logic run,
    input  logic trig_active,
    input  logic fire,
    input  logic toggle_sel,
    input  logic park_lvl,
    output logic pin
);

    pin_state_e state_q, state_d;
    logic       pin_q, pin_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (dir_out) begin
            if (!run || !trig_active)  state_d = ST_PARK;
            else if (toggle_sel)       state_d = ST_TOGGLE;
            else if (fire)             state_d = ST_PULSE;
            else                       state_d = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PARK;
        else        state_q <= state_d;
    end

    // Output level for the entered state
    always_comb begin
        pin_d = pin_q;
        if (dir_out) begin
            unique case (state_d)
                ST_PARK, ST_IDLE: pin_d = park_lvl;
                ST_TOGGLE:        pin_d = fire ? ~pin_q : pin_q;
                ST_PULSE:         pin_d = ~park_lvl;
            endcase
        end
    end

    // Output register: written only when the level changes
    always_ff @(posedge clk) begin
        if (!rst_n)              pin_q <= RST_LEVEL;
        else if (pin_d != pin_q) pin_q <= pin_d;
    end

    assign pin = pin_q;

    // R5: stopped or inactive mode parks the pin
    a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && (!run || !trig_active)) |=> (pin_q == $past(park_lvl)));

    // R6: input direction freezes pin and state
    a_r6_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |=> ($stable(pin_q) && $stable(state_q)));

    // R3: qualifying event in toggle mode inverts the pin
    a_r3_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && run && trig_active && toggle_sel && fire) |=> (pin_q != $past(pin_q)));

    // R3: no event in toggle mode keeps the pin
    a_r3_toggle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && run && trig_active && toggle_sel && !fire) |=> $stable(pin_q));

    // R4: event in pulse mode departs from park level
    a_r4_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && run && trig_active && !toggle_sel && fire) |=> (pin_q == !$past(park_lvl)));

    // R4: no event in pulse mode returns to park level
    a_r4_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && run && trig_active && !toggle_sel && !fire) |=> (pin_q == $past(park_lvl)));

endmodule

// File: rtl/tmr_pin_driver.sv
module tmr_pin_driver
    import tmr_pin_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_evt,
    input  logic       mat_evt,
    input  logic       run,
    input  logic [1:0] trig_mode,
    input  logic       toggle_sel,
    input  logic       park_lvl,
    input  logic       dir_out,
    output logic       pin_out
);

    logic trig_active;
    logic fire;

    tmr_pin_qual u_qual (
        .ovf_evt     (ovf_evt),
        .mat_evt     (mat_evt),
        .trig_mode   (trig_mode),
        .trig_active (trig_active),
        .fire        (fire)
    );

    tmr_pin_fsm #(
        .RST_LEVEL (RST_LEVEL)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_out     (dir_out),
        .run         (run),
        .trig_active (trig_active),
        .fire        (fire),
        .toggle_sel  (toggle_sel),
        .park_lvl    (park_lvl),
        .pin         (pin_out)
    );

    // R7: coincident overflow and match in mode 2'b10 toggle inverts once
    a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && run && trig_mode == 2'b10 && toggle_sel && ovf_evt && mat_evt)
        |=> (pin_out == !$past(pin_out)));

    // R8: match alone in mode 2'b01 leaves the pin unchanged under toggle
    a_r8_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && run && trig_mode == 2'b01 && toggle_sel && mat_evt && !ovf_evt)
        |=> $stable(pin_out));

    // R2: reserved mode parks like mode none
    a_r2_rsvd_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && trig_mode == 2'b11) |=> (pin_out == $past(park_lvl)));

endmodule

// File: tb/test_tmr_pin_driver.sv
module test_tmr_pin_driver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovf_evt = 1'b0;
    logic       mat_evt = 1'b0;
    logic       run = 1'b0;
    logic [1:0] trig_mode = 2'b00;
    logic       toggle_sel = 1'b0;
    logic       park_lvl = 1'b0;
    logic       dir_out = 1'b0;
    logic       pin_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  exp;
        string req;
    } sb_item_t;

    sb_item_t sb[$];
    logic     exp_pin = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    tmr_pin_driver i_tmr_pin_driver (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_evt    (ovf_evt),
        .mat_evt    (mat_evt),
        .run        (run),
        .trig_mode  (trig_mode),
        .toggle_sel (toggle_sel),
        .park_lvl   (park_lvl),
        .dir_out    (dir_out),
        .pin_out    (pin_out)
    );

    // Driver: applies one cycle of stimulus and predicts the pin after the next edge
    task automatic step(input logic o, input logic m, input logic r, input logic [1:0] md,
                        input logic t, input logic pk, input logic d, input string req);
        logic active;
        logic qual;
        sb_item_t it;
        @(negedge clk);
        ovf_evt = o; mat_evt = m; run = r; trig_mode = md;
        toggle_sel = t; park_lvl = pk; dir_out = d;
        active = (md == 2'b01) || (md == 2'b10);
        qual   = o || (md == 2'b10 && m);
        if (d) begin
            if (!r || !active) exp_pin = pk;
            else if (t)        exp_pin = qual ? ~exp_pin : exp_pin;
            else               exp_pin = qual ? ~pk : pk;
        end
        it.exp = exp_pin;
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compares after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                n_cmp++;
                if (pin_out !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: pin_out=%b expected %b at %0t", it.req, pin_out, it.exp, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (pin_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: pin_out=%b expected 0 in reset", pin_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        n_cmp++;
        if (pin_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: pin_out=%b expected 0 after reset", pin_out);
        end

        // args: ovf, mat, run, mode, toggle, park, dir
        step(0, 0, 0, 2'b01, 1, 1, 1, "R5 park high stopped");
        step(0, 0, 0, 2'b01, 1, 0, 1, "R5 park low stopped");
        step(0, 0, 1, 2'b01, 1, 0, 1, "R3 no event keeps");
        step(1, 0, 1, 2'b01, 1, 0, 1, "R3 overflow toggles");
        step(0, 0, 1, 2'b01, 1, 0, 1, "R3 idle holds");
        step(0, 1, 1, 2'b01, 1, 0, 1, "R8 match ignored mode1");
        step(1, 0, 1, 2'b01, 1, 0, 1, "R3 overflow toggles back");
        step(0, 1, 1, 2'b10, 1, 0, 1, "R2 match toggles mode2");
        step(1, 1, 1, 2'b10, 1, 0, 1, "R7 coincident single flip a");
        step(1, 1, 1, 2'b10, 1, 0, 1, "R7 coincident single flip b");
        step(0, 0, 1, 2'b10, 1, 1, 1, "R3 park ignored while toggling");
        step(1, 0, 1, 2'b00, 1, 0, 1, "R2 mode0 parks");
        step(1, 0, 1, 2'b01, 0, 0, 1, "R4 pulse high");
        step(0, 0, 1, 2'b01, 0, 0, 1, "R4 pulse ends");
        step(1, 0, 1, 2'b01, 0, 1, 1, "R4 pulse low from high idle");
        step(0, 0, 1, 2'b01, 0, 1, 1, "R4 pulse returns high");
        step(0, 1, 1, 2'b10, 0, 0, 1, "R4 match pulse mode2");
        step(1, 1, 1, 2'b10, 0, 0, 1, "R7 coincident pulse");
        step(0, 0, 1, 2'b10, 0, 0, 1, "R4 pulse train ends");
        step(1, 0, 1, 2'b11, 1, 1, 1, "R2 mode3 parks");
        step(1, 1, 1, 2'b10, 1, 0, 0, "R6 input ignores events");
        step(0, 0, 0, 2'b00, 0, 0, 0, "R6 input ignores park");
        step(0, 0, 0, 2'b00, 0, 0, 1, "R5 output reparks low");

        while (sb.size() > 0) @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule